// File: doc/BRIEF.md
# Dual circular-buffer address generator

The block produces two memory addresses in the same clock cycle, one on each of two independent address ports, so that a datapath can fetch two operands at once. It holds four buffer sets, each made of an index, a modify, a length and a base register. It also holds eight general pointer registers that serve stack-style access. All of these registers are 32 bits wide.

A port in index mode emits the current index of the selected set. It can then post-modify that index by the set's modify register or by an immediate. The new index wraps inside the circular buffer that the set's base and length describe. A port in pointer mode addresses a pointer register. It can add an immediate offset, post-increment the pointer by 4 or pre-decrement it by 4.

A single register write port loads any register. Each address port accepts a command through a valid/ready handshake. The command's ready follows the memory's ready for that port, and the address's valid follows the command's valid. A register is updated only on a cycle in which both are high, so back-pressure from the memory holds every register unchanged.

Top module: `dag_dual`

## Requirements
- R1: After reset every index, modify, length, base and pointer register reads as zero. An index-mode access with op 0 therefore emits address 0, and so does a pointer-mode access with op 0 and an immediate of 0.
- R2: In index mode the emitted address is the index value before modification. The updated index takes effect at the clock edge on which the port fires.
- R3: If a set's length is zero, the post-modified index is plain index + modify, with no wrapping.
- R4: If length is nonzero and index + modify is at or above base + length, the stored index becomes index + modify − length.
- R5: If length is nonzero and index + modify is below base, the stored index becomes index + modify + length.
- R6: The index-mode op field selects the post-modify. Op 1 adds the set's modify register. Op 2 adds the 32-bit two's-complement immediate. Op 0 and op 3 leave the index unchanged. The set is selected by bits [1:0] of the 3-bit register number.
- R7: Pointer-mode op 0 or op 3 emits pointer + immediate and leaves the pointer unchanged.
- R8: Pointer-mode op 1 (post-increment) emits the pointer and then stores pointer + 4.
- R9: Pointer-mode op 2 (pre-decrement) emits pointer − 4 and stores pointer − 4.
- R10: A port fires only when cmd_valid and addr_ready are both high. Without a fire no register changes. addr_valid equals cmd_valid, and cmd_ready equals addr_ready.
- R11: The two ports can update different registers in the same cycle, and both updates take effect.
- R12: The clash output is high when both ports fire, both update, and both target the same register (same mode and same set or pointer number). When this happens, port 0's result is the value stored.
- R13: The write port loads the register that wr_kind selects: 0 index, 1 modify, 2 length, 3 base, 4 pointer. Kinds 5 to 7 are ignored. If the write port and an address update hit the same register in the same cycle, the written data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind: 0 index, 1 modify, 2 length, 3 base, 4 pointer |
| wr_num | input | 3 | Set number (bits [1:0]) or pointer number |
| wr_data | input | 32 | Value to load |
| p0_cmd_valid | input | 1 | Port 0 command valid |
| p0_cmd_ready | output | 1 | Port 0 command accepted |
| p0_use_ptr | input | 1 | Port 0 pointer mode (1) or index mode (0) |
| p0_num | input | 3 | Port 0 register number |
| p0_op | input | 2 | Port 0 operation |
| p0_imm | input | 32 | Port 0 immediate |
| p0_addr_valid | output | 1 | Port 0 address valid |
| p0_addr_ready | input | 1 | Port 0 memory ready |
| p0_addr | output | 32 | Port 0 address |
| p1_cmd_valid | input | 1 | Port 1 command valid |
| p1_cmd_ready | output | 1 | Port 1 command accepted |
| p1_use_ptr | input | 1 | Port 1 pointer mode |
| p1_num | input | 3 | Port 1 register number |
| p1_op | input | 2 | Port 1 operation |
| p1_imm | input | 32 | Port 1 immediate |
| p1_addr_valid | output | 1 | Port 1 address valid |
| p1_addr_ready | input | 1 | Port 1 memory ready |
| p1_addr | output | 32 | Port 1 address |
| clash | output | 1 | Both ports updated the same register this cycle |

## Verification
Two pairs of functions can fall on the same cycle.

The first pair is an update from port 0 and an update from port 1 aimed at the same register. Directed steps fire both ports at one set with different modifiers. The random phase also produces such collisions often, because it draws register numbers from a small range. Each collision is judged by the clash output in that cycle and, on the next cycle, by reading the register back: the stored value must be port 0's result.

The second pair is a write-port load and an address update on the same register. That case is judged by the next read returning the written data.

// File: rtl/dag_pkg.sv
package dag_pkg;
  // register kinds for the write port
  localparam logic [2:0] WK_IDX  = 3'd0;
  localparam logic [2:0] WK_MOD  = 3'd1;
  localparam logic [2:0] WK_LEN  = 3'd2;
  localparam logic [2:0] WK_BASE = 3'd3;
  localparam logic [2:0] WK_PTR  = 3'd4;
  // index-mode operations
  localparam logic [1:0] IX_HOLD = 2'd0;
  localparam logic [1:0] IX_MREG = 2'd1;
  localparam logic [1:0] IX_IMM  = 2'd2;
  // pointer-mode operations
  localparam logic [1:0] PT_OFFS    = 2'd0;
  localparam logic [1:0] PT_POSTINC = 2'd1;
  localparam logic [1:0] PT_PREDEC  = 2'd2;
endpackage

// File: rtl/dag_circ.sv
module dag_circ #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] idx,
  input  logic [AW-1:0] modv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] len,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] raw;
  logic [AW-1:0] lim;
  logic [AW-1:0] mag;

  always_comb begin
    raw = idx + modv;
    lim = base + len;
    mag = modv[AW-1] ? (~modv + 1'b1) : modv;
    if (len == '0)        nxt = raw;
    else if (raw >= lim)  nxt = raw - len;
    else if (raw < base)  nxt = raw + len;
    else                  nxt = raw;
    // R4 R5
    if (len != '0 && idx >= base && idx < lim && mag <= len)
      wrap_range_chk: assert (nxt >= base && nxt < lim);
  end
endmodule

// File: rtl/dag_port.sv
module dag_port
  import dag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSET  = 4,
  parameter int NPTR  = 8,
  parameter int PSTEP = 4
) (
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     use_ptr,
  input  logic [$clog2(NPTR)-1:0]  num,
  input  logic [1:0]               op,
  input  logic [AW-1:0]            imm,
  output logic                     addr_valid,
  input  logic                     addr_ready,
  output logic [AW-1:0]            addr,
  input  logic [AW-1:0]            iregs [NSET],
  input  logic [AW-1:0]            mregs [NSET],
  input  logic [AW-1:0]            lregs [NSET],
  input  logic [AW-1:0]            bregs [NSET],
  input  logic [AW-1:0]            pregs [NPTR],
  output logic                     upd,
  output logic [AW-1:0]            nxt
);
  localparam int SW = $clog2(NSET);

  logic [SW-1:0] set;
  logic [AW-1:0] i_cur;
  logic [AW-1:0] p_cur;
  logic [AW-1:0] mod_val;
  logic [AW-1:0] circ_nxt;
  logic          want;

  assign set     = num[SW-1:0];
  assign i_cur   = iregs[set];
  assign p_cur   = pregs[num];
  assign mod_val = (op == IX_MREG) ? mregs[set] : imm;

  dag_circ #(.AW(AW)) u_circ (
    .idx (i_cur),
    .modv(mod_val),
    .base(bregs[set]),
    .len (lregs[set]),
    .nxt (circ_nxt)
  );

  always_comb begin
    if (use_ptr) begin
      case (op)
        PT_POSTINC: begin addr = p_cur;         nxt = p_cur + PSTEP; want = 1'b1; end
        PT_PREDEC:  begin addr = p_cur - PSTEP; nxt = p_cur - PSTEP; want = 1'b1; end
        default:    begin addr = p_cur + imm;   nxt = p_cur;         want = 1'b0; end
      endcase
    end else begin
      addr = i_cur;
      nxt  = circ_nxt;
      want = (op == IX_MREG) || (op == IX_IMM);
    end
  end

  assign cmd_ready  = addr_ready;
  assign addr_valid = cmd_valid;
  assign upd        = cmd_valid && addr_ready && want;
endmodule

// File: rtl/dag_dual.sv
module dag_dual
  import dag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSET  = 4,
  parameter int NPTR  = 8,
  parameter int PSTEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_kind,
  input  logic [2:0]    wr_num,
  input  logic [31:0]   wr_data,
  input  logic          p0_cmd_valid,
  output logic          p0_cmd_ready,
  input  logic          p0_use_ptr,
  input  logic [2:0]    p0_num,
  input  logic [1:0]    p0_op,
  input  logic [31:0]   p0_imm,
  output logic          p0_addr_valid,
  input  logic          p0_addr_ready,
  output logic [31:0]   p0_addr,
  input  logic          p1_cmd_valid,
  output logic          p1_cmd_ready,
  input  logic          p1_use_ptr,
  input  logic [2:0]    p1_num,
  input  logic [1:0]    p1_op,
  input  logic [31:0]   p1_imm,
  output logic          p1_addr_valid,
  input  logic          p1_addr_ready,
  output logic [31:0]   p1_addr,
  output logic          clash
);
  localparam int NPORT = 2;
  localparam int SW    = $clog2(NSET);
  localparam int PW    = $clog2(NPTR);

  logic [AW-1:0] iregs [NSET];
  logic [AW-1:0] mregs [NSET];
  logic [AW-1:0] lregs [NSET];
  logic [AW-1:0] bregs [NSET];
  logic [AW-1:0] pregs [NPTR];

  logic          cv   [NPORT];
  logic          crdy [NPORT];
  logic          cptr [NPORT];
  logic [PW-1:0] cn   [NPORT];
  logic [1:0]    cop  [NPORT];
  logic [AW-1:0] cimm [NPORT];
  logic          av   [NPORT];
  logic          ardy [NPORT];
  logic [AW-1:0] ca   [NPORT];
  logic          upd  [NPORT];
  logic [AW-1:0] nxt  [NPORT];

  assign cv[0] = p0_cmd_valid;  assign cv[1] = p1_cmd_valid;
  assign cptr[0] = p0_use_ptr;  assign cptr[1] = p1_use_ptr;
  assign cn[0] = p0_num;        assign cn[1] = p1_num;
  assign cop[0] = p0_op;        assign cop[1] = p1_op;
  assign cimm[0] = p0_imm;      assign cimm[1] = p1_imm;
  assign ardy[0] = p0_addr_ready; assign ardy[1] = p1_addr_ready;
  assign p0_cmd_ready = crdy[0];  assign p1_cmd_ready = crdy[1];
  assign p0_addr_valid = av[0];   assign p1_addr_valid = av[1];
  assign p0_addr = ca[0];         assign p1_addr = ca[1];

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    dag_port #(.AW(AW), .NSET(NSET), .NPTR(NPTR), .PSTEP(PSTEP)) u_port (
      .cmd_valid (cv[g]),
      .cmd_ready (crdy[g]),
      .use_ptr   (cptr[g]),
      .num       (cn[g]),
      .op        (cop[g]),
      .imm       (cimm[g]),
      .addr_valid(av[g]),
      .addr_ready(ardy[g]),
      .addr      (ca[g]),
      .iregs     (iregs),
      .mregs     (mregs),
      .lregs     (lregs),
      .bregs     (bregs),
      .pregs     (pregs),
      .upd       (upd[g]),
      .nxt       (nxt[g])
    );
  end

  // same target for both ports
  always_comb begin
    clash = upd[0] && upd[1] && (cptr[0] == cptr[1]) &&
            (cptr[0] ? (cn[0] == cn[1]) : (cn[0][SW-1:0] == cn[1][SW-1:0]));
  end

  // later assignments win: port 1, then port 0, then the write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSET; s++) begin
        iregs[s] <= '0; mregs[s] <= '0; lregs[s] <= '0; bregs[s] <= '0;
      end
      for (int p = 0; p < NPTR; p++) pregs[p] <= '0;
    end else begin
      for (int k = NPORT-1; k >= 0; k--) begin
        if (upd[k]) begin
          if (cptr[k]) pregs[cn[k]] <= nxt[k];
          else         iregs[cn[k][SW-1:0]] <= nxt[k];
        end
      end
      if (wr_en) begin
        case (wr_kind)
          WK_IDX:  iregs[wr_num[SW-1:0]] <= wr_data;
          WK_MOD:  mregs[wr_num[SW-1:0]] <= wr_data;
          WK_LEN:  lregs[wr_num[SW-1:0]] <= wr_data;
          WK_BASE: bregs[wr_num[SW-1:0]] <= wr_data;
          WK_PTR:  pregs[wr_num]          <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking state ----------------
  logic          wr_hits_p0;
  logic          chk_v, chk_ptr, wq_v;
  logic [PW-1:0] chk_num, wq_num;
  logic [AW-1:0] chk_val, wq_data, chk_cur, wq_cur;
  logic [2:0]    wq_kind;

  assign wr_hits_p0 = wr_en &&
    ((wr_kind == WK_PTR && cptr[0] && wr_num == cn[0]) ||
     (wr_kind == WK_IDX && !cptr[0] && wr_num[SW-1:0] == cn[0][SW-1:0]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v <= 1'b0; wq_v <= 1'b0;
      chk_ptr <= 1'b0; chk_num <= '0; chk_val <= '0;
      wq_kind <= '0; wq_num <= '0; wq_data <= '0;
    end else begin
      chk_v   <= upd[0] && !wr_hits_p0;
      chk_ptr <= cptr[0];
      chk_num <= cn[0];
      chk_val <= nxt[0];
      wq_v    <= wr_en && (wr_kind <= WK_PTR);
      wq_kind <= wr_kind;
      wq_num  <= wr_num;
      wq_data <= wr_data;
    end
  end

  always_comb begin
    chk_cur = chk_ptr ? pregs[chk_num] : iregs[chk_num[SW-1:0]];
    case (wq_kind)
      WK_IDX:  wq_cur = iregs[wq_num[SW-1:0]];
      WK_MOD:  wq_cur = mregs[wq_num[SW-1:0]];
      WK_LEN:  wq_cur = lregs[wq_num[SW-1:0]];
      WK_BASE: wq_cur = bregs[wq_num[SW-1:0]];
      default: wq_cur = pregs[wq_num];
    endcase
  end

  // R12
  p0_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> chk_cur == chk_val);

  // R13
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wq_v |-> wq_cur == wq_data);

  // R8
  postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd[0] && cptr[0] && cop[0] == PT_POSTINC && !wr_en)
      |=> pregs[$past(cn[0])] == $past(ca[0]) + PSTEP);

  // R9
  predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd[0] && cptr[0] && cop[0] == PT_PREDEC && !wr_en)
      |=> pregs[$past(cn[0])] == $past(ca[0]));
endmodule

// File: tb/test_dag_dual.sv
`timescale 1ns/1ps
module test_dag_dual;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0; logic [2:0] wr_kind = 0, wr_num = 0; logic [31:0] wr_data = 0;
  logic p0_cmd_valid = 0, p0_use_ptr = 0, p0_addr_ready = 0;
  logic [2:0] p0_num = 0; logic [1:0] p0_op = 0; logic [31:0] p0_imm = 0;
  logic p1_cmd_valid = 0, p1_use_ptr = 0, p1_addr_ready = 0;
  logic [2:0] p1_num = 0; logic [1:0] p1_op = 0; logic [31:0] p1_imm = 0;
  logic p0_cmd_ready, p0_addr_valid, p1_cmd_ready, p1_addr_valid, clash;
  logic [31:0] p0_addr, p1_addr;

  int checks = 0, errors = 0;
  logic [31:0] mi [4], mm [4], ml [4], mb [4], mp [8];

  always #10 clk = ~clk;   // 50 MHz

  dag_dual i_dag_dual (.*);

  function automatic logic [31:0] fwrap(logic [31:0] i, logic [31:0] m, logic [31:0] b, logic [31:0] l);
    logic [31:0] r = i + m;
    if (l == 0) return r;
    if (r >= b + l) return r - l;
    if (r < b) return r + l;
    return r;
  endfunction

  task automatic calc(input bit pt, input [2:0] n, input [1:0] o, input [31:0] im,
                      output logic [31:0] ea, output logic [31:0] en, output bit eu);
    if (pt) begin
      case (o)
        2'd1:    begin ea = mp[n];     en = mp[n] + 4; eu = 1; end
        2'd2:    begin ea = mp[n] - 4; en = mp[n] - 4; eu = 1; end
        default: begin ea = mp[n] + im; en = mp[n];    eu = 0; end
      endcase
    end else begin
      ea = mi[n[1:0]];
      eu = (o == 2'd1) || (o == 2'd2);
      en = fwrap(mi[n[1:0]], (o == 2'd1) ? mm[n[1:0]] : im, mb[n[1:0]], ml[n[1:0]]);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input string tag,
      input bit v0, input bit pt0, input [2:0] n0, input [1:0] o0, input [31:0] im0, input bit r0,
      input bit v1, input bit pt1, input [2:0] n1, input [1:0] o1, input [31:0] im1, input bit r1,
      input bit we, input [2:0] wk, input [2:0] wn, input [31:0] wd);
    logic [31:0] ea0, en0, ea1, en1; bit eu0, eu1, f0, f1, ec;
    @(negedge clk);
    p0_cmd_valid = v0; p0_use_ptr = pt0; p0_num = n0; p0_op = o0; p0_imm = im0; p0_addr_ready = r0;
    p1_cmd_valid = v1; p1_use_ptr = pt1; p1_num = n1; p1_op = o1; p1_imm = im1; p1_addr_ready = r1;
    wr_en = we; wr_kind = wk; wr_num = wn; wr_data = wd;
    #5;
    calc(pt0, n0, o0, im0, ea0, en0, eu0);
    calc(pt1, n1, o1, im1, ea1, en1, eu1);
    f0 = v0 && r0 && eu0; f1 = v1 && r1 && eu1;
    ec = f0 && f1 && (pt0 == pt1) && (pt0 ? (n0 == n1) : (n0[1:0] == n1[1:0]));
    chk({tag, " R10 valid0"}, {31'd0, p0_addr_valid}, {31'd0, v0});
    chk({tag, " R10 ready1"}, {31'd0, p1_cmd_ready}, {31'd0, r1});
    if (v0) chk({tag, " addr0"}, p0_addr, ea0);
    if (v1) chk({tag, " addr1"}, p1_addr, ea1);
    chk({tag, " R12 clash"}, {31'd0, clash}, {31'd0, ec});
    if (f1) begin if (pt1) mp[n1] = en1; else mi[n1[1:0]] = en1; end
    if (f0) begin if (pt0) mp[n0] = en0; else mi[n0[1:0]] = en0; end
    if (we) case (wk)
      3'd0: mi[wn[1:0]] = wd;
      3'd1: mm[wn[1:0]] = wd;
      3'd2: ml[wn[1:0]] = wd;
      3'd3: mb[wn[1:0]] = wd;
      3'd4: mp[wn] = wd;
      default: ;
    endcase
  endtask

  task automatic wr(input string tag, input [2:0] k, input [2:0] n, input [31:0] d);
    step(tag, 0,0,0,0,0,1, 0,0,0,0,0,1, 1, k, n, d);
  endtask
  task automatic op0(input string tag, input bit pt, input [2:0] n, input [1:0] o, input [31:0] im);
    step(tag, 1,pt,n,o,im,1, 0,0,0,0,0,1, 0,0,0,0);
  endtask
  task automatic cfg(input string tag, input [2:0] s, input [31:0] b, input [31:0] l,
                     input [31:0] m, input [31:0] i);
    wr(tag, 3'd2, s, l); wr(tag, 3'd3, s, b); wr(tag, 3'd1, s, m); wr(tag, 3'd0, s, i);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    for (int s = 0; s < 4; s++) begin mi[s] = 0; mm[s] = 0; ml[s] = 0; mb[s] = 0; end
    for (int p = 0; p < 8; p++) mp[p] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 4; s++) op0("R1 idx", 0, 3'(s), 2'd0, 0);
    for (int p = 0; p < 8; p++) op0("R1 ptr", 1, 3'(p), 2'd0, 0);
    // R2 R4 upper wrap: 0x10C +4 -> 0x100
    cfg("R13 cfg", 0, 32'h100, 16, 4, 32'h10C);
    op0("R2 R4", 0, 0, 2'd1, 0);
    op0("R4 wrapped", 0, 0, 2'd1, 0);
    chk("R4 direct", p0_addr, 32'h100);
    // R5 lower wrap: 0x104 -8 -> 0x10C
    wr("R5 cfg", 3'd1, 0, -32'sd8);
    op0("R5", 0, 0, 2'd1, 0);
    op0("R5 wrapped", 0, 0, 2'd0, 0);
    chk("R5 direct", p0_addr, 32'h10C);
    // R6 immediate
    op0("R6 imm", 0, 0, 2'd2, -32'sd2);
    op0("R6 after", 0, 0, 2'd3, 0);
    chk("R6 direct", p0_addr, 32'h10A);
    // R3 linear
    cfg("R3 cfg", 1, 32'h200, 0, 32'h20, 32'h3F0);
    op0("R3", 0, 1, 2'd1, 0);
    op0("R3", 0, 1, 2'd1, 0);
    op0("R3 end", 0, 1, 2'd0, 0);
    chk("R3 direct", p0_addr, 32'h430);
    // pointers
    wr("R13 ptr", 3'd4, 5, 32'h8000);
    op0("R7 offset", 1, 5, 2'd0, 32'h24);
    chk("R7 direct", p0_addr, 32'h8024);
    op0("R8 postinc", 1, 5, 2'd1, 0);
    op0("R8 after", 1, 5, 2'd0, 0);
    chk("R8 direct", p0_addr, 32'h8004);
    op0("R9 predec", 1, 5, 2'd2, 0);
    chk("R9 direct", p0_addr, 32'h8000);
    op0("R9 after", 1, 5, 2'd0, 0);
    // R10 back-pressure
    step("R10 stall", 1,0,0,2'd1,0,0, 1,1,5,2'd1,0,0, 0,0,0,0);
    op0("R10 held", 0, 0, 2'd0, 0);
    chk("R10 direct", p0_addr, 32'h10A);
    // R11 two sets in one cycle
    step("R11", 1,0,0,2'd2,32'h4,1, 1,0,1,2'd2,32'h8,1, 0,0,0,0);
    step("R11 rd", 1,0,0,2'd0,0,1, 1,0,1,2'd0,0,1, 0,0,0,0);
    chk("R11 direct1", p1_addr, 32'h438);
    // R12 clash on set 2
    cfg("R12 cfg", 2, 32'h300, 32, 2, 32'h310);
    step("R12 both", 1,0,2,2'd2,32'h1,1, 1,0,6,2'd2,32'h5,1, 0,0,0,0);
    op0("R12 winner", 0, 2, 2'd0, 0);
    chk("R12 direct", p0_addr, 32'h311);
    // R13 write beats update, unknown kinds ignored
    step("R13 race", 1,0,2,2'd1,0,1, 0,0,0,0,0,1, 1,3'd0,2,32'h31C);
    op0("R13 rd", 0, 2, 2'd0, 0);
    chk("R13 direct", p0_addr, 32'h31C);
    wr("R13 kind7", 3'd7, 2, 32'hDEAD);
    op0("R13 ignored", 0, 2, 2'd0, 0);
    chk("R13 ignored direct", p0_addr, 32'h31C);
    // random
    for (int it = 0; it < 3000; it++) begin
      if (it % 250 == 0) begin
        logic [31:0] b, l, m;
        int s = $urandom_range(0, 3);
        b = 32'h1000 + 32'($urandom_range(0, 255)) * 16;
        l = ($urandom_range(0, 3) == 0) ? 0 : 32'($urandom_range(16, 64));
        m = 32'($signed($urandom_range(0, 16)) - 8);
        cfg("RND R4 R5 cfg", 3'(s), b, l, m, b + 32'($urandom_range(0, 15)));
      end else begin
        step("RND R2 R11 R12",
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)),
          2'($urandom_range(0, 3)), 32'($signed($urandom_range(0, 16)) - 8), $urandom_range(0, 4) != 0,
          $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, 3'($urandom_range(0, 7)),
          2'($urandom_range(0, 3)), 32'($signed($urandom_range(0, 16)) - 8), $urandom_range(0, 4) != 0,
          $urandom_range(0, 19) == 0, 3'd4, 3'($urandom_range(0, 7)), 32'h9000 + 32'($urandom_range(0, 255)) * 4);
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule